// File: doc/BRIEF.md
# Pipelined merge sort engine

The engine takes a block of `N` unsigned words, one per clock, and returns the same words in ascending order, one per clock, on a valid/data output stream. Inside, the incoming stream is cut into groups of `G` words. Each full group is ordered in one step by a compare-exchange network and then sent out serially into a chain of merge stages. Each merge stage fills two queues with a pair of sorted runs and, on every cycle, emits the smaller of the two queue heads. Each stage doubles the run length, so with the defaults runs grow from 8 to 16, 32 and finally 64.

Every stage boundary is registered, so the sorting network and the merge comparators never share a clock cycle. A block fed without gaps comes out as an unbroken stream after a fixed latency. A new block may follow the previous one on the very next clock. A start marker aligns grouping to a block's first word. Words word width `W`, block size `N` and group size `G` are parameters, with `N/G` and `G` powers of two.

Top module: `merge_sort_pipe`

## Requirements
- R1: While reset is held and after its release, `out_valid` stays low until sorted data of a complete block is produced.
- R2: The `N` words output for a block appear in non-decreasing order.
- R3: The words output for a block are exactly the words input for it, with duplicates kept, and no extra words follow.
- R4: A block supplied on `N` consecutive clocks is output on `N` consecutive clocks.
- R5: With the engine idle, if a block's first word is sampled at clock edge t, then `out_valid` is first high after edge t + N + 2*log2(N/G), which is 70 with the defaults.
- R6: A block may begin on the clock after the previous block's last word. Both blocks are then output as one unbroken run of 2N words, each half sorted on its own, and the second half starts N cycles after the first.
- R7: A word presented with `in_first` high becomes the first word of a fresh group. Words received before it that never completed a group are discarded and never output.
- R8: Idle cycles between the words of a block do not change the sorted content that is output.
- R9: Comparison is unsigned over the full width. All-zero and all-ones words, repeated values and constant blocks are ordered correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_first | input | 1 | Marks the first word of a block |
| in_data | input | W | Input word |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | W | Sorted output word |

## Verification
In a merge stage, two things can happen on the same clock edge: the first run of the next pair is written into a queue, and the tail of the current pair is drained from that queue. In the serializer, the reload of a fresh sorted group lands on the same edge as the shift-out of the previous group's last word. Both overlaps are forced by feeding two blocks back to back with no idle cycle between them. The result is judged by requiring 2N output words on consecutive cycles, each half matching its own block's sorted content, and the second half starting exactly N cycles after the first.

// File: rtl/merge_sort_pipe.sv
module merge_sort_pipe #(
  parameter int W = 16,
  parameter int N = 64,
  parameter int G = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int GB = $clog2(G);
  localparam int S  = $clog2(N / G);

  logic [W-1:0]      grp [G];
  logic [W-1:0]      srt [G];
  logic [W-1:0]      sh  [G];
  logic [GB-1:0]     gi;
  logic              grp_full;
  logic [GB:0]       scnt;
  logic [S:0]        sv;
  logic [S:0][W-1:0] sd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gi       <= '0;
      grp_full <= 1'b0;
    end else begin
      grp_full <= in_valid && !in_first && gi == GB'(G - 1);
      if (in_valid) gi <= in_first ? GB'(1) : gi + GB'(1);
    end

  always_ff @(posedge clk)
    if (in_valid) grp[in_first ? GB'(0) : gi] <= in_data;

  always_comb begin
    logic [W-1:0] t;
    t = '0;
    for (int i = 0; i < G; i++) srt[i] = grp[i];
    for (int r = 0; r < G; r++)
      for (int i = r % 2; i + 1 < G; i += 2)
        if (srt[i] > srt[i+1]) begin
          t        = srt[i];
          srt[i]   = srt[i+1];
          srt[i+1] = t;
        end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             scnt <= '0;
    else if (grp_full)      scnt <= (GB+1)'(G);
    else if (scnt != '0)    scnt <= scnt - 1'b1;

  always_ff @(posedge clk)
    if (grp_full) sh <= srt;
    else for (int i = 0; i < G - 1; i++) sh[i] <= sh[i+1];

  assign sv[0] = scnt != '0;
  assign sd[0] = sh[0];

  genvar k;
  generate
    for (k = 0; k < S; k++) begin : g_merge
      localparam int L  = G << k;
      localparam int AW = GB + k + 1;

      logic [W-1:0]  qa [2*L];
      logic [W-1:0]  qb [2*L];
      logic [AW-1:0] wa, ra, wb, rb, ic, ca, cb;
      logic [AW:0]   na, nb;
      logic [W-1:0]  ha, hb, od;
      logic          wr_a, wr_b, a_done, b_done, a_ok, b_ok;
      logic          take_a, take_b, fire, pair_end, ov;

      assign wr_a   = sv[k] && !ic[AW-1];
      assign wr_b   = sv[k] &&  ic[AW-1];
      assign a_done = ca == AW'(L);
      assign b_done = cb == AW'(L);
      assign a_ok   = na != '0;
      assign b_ok   = nb != '0;
      assign ha     = qa[ra];
      assign hb     = qb[rb];
      assign take_a = !a_done && a_ok && (b_done || (b_ok && ha <= hb));
      assign take_b = !b_done && b_ok && (a_done || (a_ok && hb <  ha));
      assign fire   = take_a || take_b;
      assign pair_end = (take_a && b_done && ca == AW'(L - 1)) ||
                        (take_b && a_done && cb == AW'(L - 1));

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ic <= '0; wa <= '0; wb <= '0; ra <= '0; rb <= '0;
          ca <= '0; cb <= '0; na <= '0; nb <= '0; ov <= 1'b0;
        end else begin
          ic <= ic + AW'(sv[k]);
          wa <= wa + AW'(wr_a);
          wb <= wb + AW'(wr_b);
          ra <= ra + AW'(take_a);
          rb <= rb + AW'(take_b);
          na <= na + (AW+1)'(wr_a) - (AW+1)'(take_a);
          nb <= nb + (AW+1)'(wr_b) - (AW+1)'(take_b);
          ca <= pair_end ? '0 : ca + AW'(take_a);
          cb <= pair_end ? '0 : cb + AW'(take_b);
          ov <= fire;
        end

      always_ff @(posedge clk) begin
        if (wr_a) qa[wa] <= sd[k];
        if (wr_b) qb[wb] <= sd[k];
        if (fire) od <= take_a ? ha : hb;
      end

      assign sv[k+1] = ov;
      assign sd[k+1] = od;
    end
  endgenerate

  assign out_valid = sv[S];
  assign out_data  = sd[S];
endmodule

// File: rtl/merge_sort_pipe_chk.sv
module merge_sort_pipe_chk #(
  parameter int W = 16,
  parameter int N = 64
)(
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  logic [31:0]  in_cnt, out_cnt, opos;
  logic [W-1:0] last_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_cnt <= '0; out_cnt <= '0; opos <= '0; last_d <= '0;
    end else begin
      if (in_valid) in_cnt <= in_cnt + 1;
      if (out_valid) begin
        out_cnt <= out_cnt + 1;
        opos    <= (opos == 32'(N - 1)) ? '0 : opos + 1;
        last_d  <= out_data;
      end
    end

  assert_quiet_in_reset_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && opos != '0 |-> out_data >= last_d);

  assert_known_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));

  assert_no_invented_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cnt < in_cnt);
endmodule

bind merge_sort_pipe merge_sort_pipe_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_merge_sort_pipe.sv
module test_merge_sort_pipe;
  localparam int W   = 16;
  localparam int N   = 64;
  localparam int G   = 8;
  localparam int LAT = N + 2 * $clog2(N / G);

  // table: mode, seed (mode 4 = extremes R9, mode 3 = constant R9, mode 5 = duplicates R9)
  localparam int NT = 8;
  localparam int TMODE [NT] = '{0, 1, 2, 3, 4, 5, 6, 0};
  localparam int TSEED [NT] = '{11, 5, 0, 16'h1234, 0, 3, 0, 977};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int errors = 0, checks = 0, cyc = 0, ocount = 0, bcount = 0;
  logic [W-1:0] obuf [0:1023];
  int           ocyc [0:1023];
  logic [W-1:0] blk  [0:1023];

  merge_sort_pipe #(.W(W), .N(N), .G(G)) i_merge_sort_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && out_valid && ocount < 1024) begin
      obuf[ocount] = out_data;
      ocyc[ocount] = cyc;
      ocount++;
    end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen(int mode, int seed, int i);
    int x;
    case (mode)
      0: begin x = i * 40503 + seed * 7919; x = x ^ (x >>> 7); return W'(x ^ (x << 3)); end
      1: return W'(N - 1 - i + seed);
      2: return W'(i * 3);
      3: return W'(seed);
      4: return (i % 3 == 0) ? {W{1'b1}} : (i % 3 == 1) ? W'(0) : W'(i * 1021);
      5: return W'((i * 7 + seed) % 4);
      default: return W'((G - 1 - i / G) * 100 + (i % G));
    endcase
  endfunction

  task automatic drive_block(int mode, int seed, bit gaps, output int t_in);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == 0) t_in = cyc + 1;
      in_valid = 1'b1;
      in_first = (i == 0);
      in_data  = gen(mode, seed, i);
      blk[bcount + i] = in_data;
      if (gaps && i % 3 == 2) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
      end
    end
    bcount += N;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_content(string req, int src, int obase);
    logic [W-1:0] e [0:N-1];
    logic [W-1:0] t;
    int bad;
    for (int i = 0; i < N; i++) e[i] = blk[src + i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j + 1 < N - i; j++)
        if (e[j] > e[j+1]) begin t = e[j]; e[j] = e[j+1]; e[j+1] = t; end
    bad = -1;
    for (int i = N - 1; i >= 0; i--) if (obuf[obase + i] !== e[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s word %0d actual=%h expected=%h", req, bad, obuf[obase + bad], e[bad]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R4 actual=hung expected=completion");
    report();
    $finish;
  end

  initial begin
    int t0, t1, ob, sb;
    // R1: quiet during and after reset
    repeat (5) @(negedge clk);
    check_int("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_int("R1 no output after reset", ocount, 0);

    // table walk: R2 R3 R4 R5 R9
    for (int k = 0; k < NT; k++) begin
      ob = ocount; sb = bcount;
      drive_block(TMODE[k], TSEED[k], 1'b0, t0);
      idle(0);
      wait (ocount >= ob + N);
      repeat (3) @(negedge clk);
      check_content($sformatf("R2,R3,R9 table %0d", k), sb, ob);
      check_int("R4 consecutive output", ocyc[ob + N - 1] - ocyc[ob], N - 1);
      check_int("R5 latency", ocyc[ob] - t0, LAT);
    end

    // R6: back-to-back blocks
    ob = ocount; sb = bcount;
    drive_block(0, 4242, 1'b0, t0);
    drive_block(6, 0, 1'b0, t1);
    idle(0);
    wait (ocount >= ob + 2 * N);
    repeat (3) @(negedge clk);
    check_content("R6 first block", sb, ob);
    check_content("R6 second block", sb + N, ob + N);
    check_int("R6 unbroken run", ocyc[ob + 2 * N - 1] - ocyc[ob], 2 * N - 1);
    check_int("R6 second block start", ocyc[ob + N] - t1, LAT);

    // R7: stray words discarded by start marker
    ob = ocount;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = 1'b0; in_data = {W{1'b1}};
    end
    idle(2);
    sb = bcount;
    drive_block(1, 300, 1'b0, t0);
    idle(0);
    wait (ocount >= ob + N);
    repeat (150) @(negedge clk);
    check_content("R7 realigned block", sb, ob);
    check_int("R7 stray words not output", ocount - ob, N);

    // R8: idle cycles inside a block
    ob = ocount; sb = bcount;
    drive_block(0, 77, 1'b1, t0);
    idle(0);
    wait (ocount >= ob + N);
    repeat (150) @(negedge clk);
    check_content("R8 gapped block", sb, ob);
    check_int("R8,R3 output count", ocount - ob, N);

    report();
    $finish;
  end
endmodule